// File: doc/BRIEF.md
# Photon Histogram Accumulator

This block builds a photon-arrival histogram in on-chip memory. Each photon accepted during a collection carries a time-channel value from the timing converter and a routing code. The block increments the memory cell whose address is the routing code placed above the time channel. The routing code therefore picks a sub-histogram and the time channel picks the bin inside it. Every cell is a saturating counter. A run-level policy decides what happens when a counter is already at full scale: keep counting elsewhere, end the run, or restart the collection window and raise a correction flag.

A host-style command port starts and stops a run, zeroes the whole memory, and reads cells back one at a time while the run is stopped. The collection window and an optional pause between repeated collections are counted in ticks. One tick is a fixed number of clock cycles, which is 0.1 µs at the default parameters. After each accepted photon the block ignores further photons for a fixed dead time of a parameter number of cycles (80 ns by default). The increment is a read-modify-write with one pipeline stage. A second photon that hits the cell still being written is forwarded, so no count is lost.

Top module: `photon_histogram`

## Requirements
- R1: Each cell counts up to 2^CNT_W−1 (16-bit by default) and never wraps. With `ovfMode`=0 (none; 3 behaves the same), a photon hitting a full cell leaves it at full scale and the run continues.
- R2: A photon is added to the cell at address {`photonRoute`, `photonTime`}: route in the upper ROUTE_W bits, time channel in the lower TIME_W bits. `rdAddr` uses the same layout.
- R3: A photon is counted only if `photonValid` and `countEnable` are both high while `collecting` is high. All other photons leave the memory unchanged.
- R4: After a photon is accepted, the next DEAD_CYC−1 cycles accept no photon. The photon in the cycle DEAD_CYC after the accepted one may be accepted again.
- R5: With `ovfMode`=1 (stop), a photon hitting a full cell leaves the cell at full scale and ends the run: `runActive` is low two cycles after that photon.
- R6: With `ovfMode`=2 (repeat-and-correct), a photon hitting a full cell leaves the cell at full scale, sets `correctNeeded`, and restarts the collection window. `collectDone` then comes COLLECT_TIME·TICK_DIV+2 cycles after the cycle that carried the photon.
- R7: Photons accepted in consecutive cycles on the same cell each add one; none is lost (possible when DEAD_CYC=1).
- R8: `cmdClear` in idle zeroes every cell, one per cycle, with `clearBusy` high for exactly 2^(ROUTE_W+TIME_W) cycles. `cmdClear` is ignored while a run is active.
- R9: `cmdStart` in idle raises `collecting` for exactly `collectTime`·TICK_DIV cycles (collectTime ≥ 1). `collectDone` pulses for one cycle in the cycle after the last of them, and with `repeatEnable` low the block returns to idle.
- R10: With `repeatEnable` high, expiry of the collection leaves `runActive` high with `collecting` low for `repeatTime`·TICK_DIV cycles (repeatTime ≥ 1). A new collection window follows.
- R11: `rdReq` in idle with no clear in progress returns the addressed cell on `rdData` with `rdValid` high in the next cycle. `rdReq` while running or clearing gives no `rdValid`.
- R12: `cmdStop` ends the run (and any repeat pause) at the next edge. `cmdStart` clears `correctNeeded`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| photonValid | input | 1 | A photon is presented this cycle |
| photonTime | input | TIME_W | Time-channel value of the photon |
| photonRoute | input | ROUTE_W | Routing code of the photon |
| countEnable | input | 1 | Counting gate |
| cmdStart | input | 1 | Start a run (idle only) |
| cmdStop | input | 1 | Stop the run |
| cmdClear | input | 1 | Zero the memory (idle only) |
| ovfMode | input | 2 | Full-scale policy: 0 none, 1 stop, 2 repeat-and-correct |
| collectTime | input | TIMER_W | Collection window in ticks |
| repeatEnable | input | 1 | Repeat collections after a pause |
| repeatTime | input | TIMER_W | Pause between collections in ticks |
| rdReq | input | 1 | Read-back request |
| rdAddr | input | ROUTE_W+TIME_W | Read-back address {route, time} |
| rdData | output | CNT_W | Read-back cell value |
| rdValid | output | 1 | rdData holds a requested cell |
| runActive | output | 1 | Collecting or pausing between collections |
| collecting | output | 1 | Collection window open |
| collectDone | output | 1 | One-cycle pulse at window expiry |
| correctNeeded | output | 1 | A counter hit full scale in repeat-and-correct mode |
| clearBusy | output | 1 | Memory clear in progress |

## Verification
The bench builds two copies at ROUTE_W=2, TIME_W=3, CNT_W=4 and TICK_DIV=2. This gives a 32-cell memory that can be read back in full after every scenario, and counters that saturate at 15 within a few dozen photons, so all three full-scale policies are reached. The two copies share every input. One has DEAD_CYC=3, so the dead-time gaps show up. The other has DEAD_CYC=1, so back-to-back photons on one cell exercise the forwarding path. Collection and pause windows are a few ticks long, so the expiry, repeat and restart timings are checked to the exact cycle.

// File: rtl/phist_pkg.sv
package phist_pkg;

  typedef enum logic [1:0] {
    OVF_NONE   = 2'd0,
    OVF_STOP   = 2'd1,
    OVF_REPEAT = 2'd2
  } ovf_mode_e;

  typedef enum logic [1:0] {
    RS_IDLE    = 2'd0,
    RS_COLLECT = 2'd1,
    RS_WAIT    = 2'd2
  } run_state_e;

  // strobes from control to datapath
  typedef struct packed {
    logic countGo;
    logic clearGo;
    logic readGo;
  } ctrl_strobe_t;

endpackage

// File: rtl/phist_ctrl.sv
module phist_ctrl
  import phist_pkg::*;
#(
  parameter int TIMER_W  = 32,
  parameter int TICK_DIV = 10,
  parameter int DEAD_CYC = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               photonValid,
  input  logic               countEnable,
  input  logic               cmdStart,
  input  logic               cmdStop,
  input  logic               cmdClear,
  input  logic               rdReq,
  input  logic [1:0]         ovfMode,
  input  logic [TIMER_W-1:0] collectTime,
  input  logic               repeatEnable,
  input  logic [TIMER_W-1:0] repeatTime,
  input  logic               satHit,
  input  logic               clearBusy,
  output ctrl_strobe_t       strobe,
  output logic               runActive,
  output logic               collecting,
  output logic               collectDone,
  output logic               correctNeeded
);

  localparam int PRE_W  = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
  localparam int DEAD_W = $clog2(DEAD_CYC + 1);
  localparam logic [PRE_W-1:0]  PRE_LAST  = PRE_W'(TICK_DIV - 1);
  localparam logic [DEAD_W-1:0] DEAD_INIT = DEAD_W'(DEAD_CYC - 1);

  run_state_e         state;
  logic [PRE_W-1:0]   preCnt;
  logic [TIMER_W-1:0] tickCnt;
  logic [DEAD_W-1:0]  deadCnt;
  logic [TIMER_W-1:0] limit;
  logic               tickEdge;
  logic               expire;
  logic               idleFree;
  logic               startGo;

  always_comb begin
    idleFree       = (state == RS_IDLE) && !clearBusy;
    startGo        = cmdStart && idleFree;
    strobe.readGo  = rdReq && idleFree;
    strobe.clearGo = cmdClear && idleFree;
    strobe.countGo = photonValid && countEnable && (state == RS_COLLECT)
                     && (deadCnt == '0);
    limit          = (state == RS_WAIT) ? repeatTime : collectTime;
    tickEdge       = (preCnt == PRE_LAST);
    expire         = tickEdge && (tickCnt == limit - 1'b1);
    runActive      = (state != RS_IDLE);
    collecting     = (state == RS_COLLECT);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state         <= RS_IDLE;
      preCnt        <= '0;
      tickCnt       <= '0;
      deadCnt       <= '0;
      collectDone   <= 1'b0;
      correctNeeded <= 1'b0;
    end else begin
      collectDone <= 1'b0;
      if (strobe.countGo)      deadCnt <= DEAD_INIT;
      else if (deadCnt != '0)  deadCnt <= deadCnt - 1'b1;

      case (state)
        RS_IDLE: begin
          if (startGo) begin
            state         <= RS_COLLECT;
            preCnt        <= '0;
            tickCnt       <= '0;
            correctNeeded <= 1'b0;
          end
        end
        RS_COLLECT: begin
          if (cmdStop) begin
            state <= RS_IDLE;
          end else if (satHit && ovfMode == OVF_STOP) begin
            state <= RS_IDLE;
          end else if (satHit && ovfMode == OVF_REPEAT) begin
            preCnt        <= '0;
            tickCnt       <= '0;
            correctNeeded <= 1'b1;
          end else if (expire) begin
            collectDone <= 1'b1;
            preCnt      <= '0;
            tickCnt     <= '0;
            state       <= repeatEnable ? RS_WAIT : RS_IDLE;
          end else if (tickEdge) begin
            preCnt  <= '0;
            tickCnt <= tickCnt + 1'b1;
          end else begin
            preCnt <= preCnt + 1'b1;
          end
        end
        RS_WAIT: begin
          if (cmdStop) begin
            state <= RS_IDLE;
          end else if (expire) begin
            state   <= RS_COLLECT;
            preCnt  <= '0;
            tickCnt <= '0;
          end else if (tickEdge) begin
            preCnt  <= '0;
            tickCnt <= tickCnt + 1'b1;
          end else begin
            preCnt <= preCnt + 1'b1;
          end
        end
        default: state <= RS_IDLE;
      endcase
    end
  end

  // R4: no acceptance in the cycle after an accepted photon when dead time spans cycles
  assert_dead_gap_R4: assert property (@(posedge clk) disable iff (!rstN)
    (DEAD_CYC > 1 && strobe.countGo) |=> !strobe.countGo);

  // R5: a saturating hit in stop mode ends the run
  assert_stop_ends_R5: assert property (@(posedge clk) disable iff (!rstN)
    (collecting && satHit && ovfMode == OVF_STOP) |=> !runActive);

  // R9: done is a single-cycle pulse
  assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rstN)
    collectDone |=> !collectDone);

  // R12: a stop command always leaves the run
  assert_stop_cmd_R12: assert property (@(posedge clk) disable iff (!rstN)
    (runActive && cmdStop) |=> !runActive);

endmodule

// File: rtl/phist_datapath.sv
module phist_datapath
  import phist_pkg::*;
#(
  parameter int ADDR_W = 11,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrl_strobe_t      strobe,
  input  logic [ADDR_W-1:0] photonAddr,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic [CNT_W-1:0]  rdData,
  output logic              rdValid,
  output logic              satHit,
  output logic              clearBusy
);

  localparam int DEPTH = 1 << ADDR_W;
  localparam logic [CNT_W-1:0]  CNT_MAX   = {CNT_W{1'b1}};
  localparam logic [ADDR_W-1:0] ADDR_LAST = ADDR_W'(DEPTH - 1);

  logic [CNT_W-1:0]  mem [DEPTH];

  logic              stgValid;
  logic [ADDR_W-1:0] stgAddr;
  logic [CNT_W-1:0]  rawWord;
  logic              fwdValid;
  logic [ADDR_W-1:0] fwdAddr;
  logic [CNT_W-1:0]  fwdData;
  logic [CNT_W-1:0]  baseWord;
  logic [CNT_W-1:0]  incWord;
  logic [ADDR_W-1:0] clrAddr;

  // increment stage: take the word written last cycle if it is the same cell
  always_comb begin
    baseWord = (fwdValid && fwdAddr == stgAddr) ? fwdData : rawWord;
    satHit   = stgValid && (baseWord == CNT_MAX);
    incWord  = (baseWord == CNT_MAX) ? baseWord : baseWord + 1'b1;
  end

  // storage: clear sweep has the write port over the increment
  always_ff @(posedge clk) begin
    if (clearBusy)      mem[clrAddr] <= '0;
    else if (stgValid)  mem[stgAddr] <= incWord;
    if (strobe.countGo) rawWord <= mem[photonAddr];
    if (strobe.readGo)  rdData  <= mem[rdAddr];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stgValid  <= 1'b0;
      stgAddr   <= '0;
      fwdValid  <= 1'b0;
      fwdAddr   <= '0;
      fwdData   <= '0;
      rdValid   <= 1'b0;
      clearBusy <= 1'b0;
      clrAddr   <= '0;
    end else begin
      stgValid <= strobe.countGo;
      if (strobe.countGo) stgAddr <= photonAddr;
      fwdValid <= stgValid;
      if (stgValid) begin
        fwdAddr <= stgAddr;
        fwdData <= incWord;
      end
      rdValid <= strobe.readGo;
      if (clearBusy) begin
        if (clrAddr == ADDR_LAST) clearBusy <= 1'b0;
        clrAddr <= clrAddr + 1'b1;
      end else if (strobe.clearGo) begin
        clearBusy <= 1'b1;
        clrAddr   <= '0;
      end
    end
  end

  // R7: back-to-back hits on one cell add exactly one each (or stay at full scale)
  assert_fwd_chain_R7: assert property (@(posedge clk) disable iff (!rstN)
    (stgValid && $past(stgValid) && stgAddr == $past(stgAddr))
      |-> (incWord == $past(incWord) + 1'b1 || incWord == CNT_MAX));

  // R8: the clear sweep only ends after the last address
  assert_clear_len_R8: assert property (@(posedge clk) disable iff (!rstN)
    $fell(clearBusy) |-> $past(clrAddr) == ADDR_LAST);

  // R1: a full cell stays full
  assert_no_wrap_R1: assert property (@(posedge clk) disable iff (!rstN)
    (stgValid && fwdValid && fwdAddr == stgAddr && fwdData == CNT_MAX)
      |-> incWord == CNT_MAX);

endmodule

// File: rtl/photon_histogram.sv
module photon_histogram
  import phist_pkg::*;
#(
  parameter int ROUTE_W  = 7,
  parameter int TIME_W   = 4,
  parameter int CNT_W    = 16,
  parameter int TIMER_W  = 32,
  parameter int TICK_DIV = 10,
  parameter int DEAD_CYC = 8
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic                      photonValid,
  input  logic [TIME_W-1:0]         photonTime,
  input  logic [ROUTE_W-1:0]        photonRoute,
  input  logic                      countEnable,
  input  logic                      cmdStart,
  input  logic                      cmdStop,
  input  logic                      cmdClear,
  input  logic [1:0]                ovfMode,
  input  logic [TIMER_W-1:0]        collectTime,
  input  logic                      repeatEnable,
  input  logic [TIMER_W-1:0]        repeatTime,
  input  logic                      rdReq,
  input  logic [ROUTE_W+TIME_W-1:0] rdAddr,
  output logic [CNT_W-1:0]          rdData,
  output logic                      rdValid,
  output logic                      runActive,
  output logic                      collecting,
  output logic                      collectDone,
  output logic                      correctNeeded,
  output logic                      clearBusy
);

  localparam int ADDR_W = ROUTE_W + TIME_W;

  ctrl_strobe_t      strobe;
  logic              satHit;
  logic [ADDR_W-1:0] photonAddr;

  assign photonAddr = {photonRoute, photonTime};

  phist_ctrl #(
    .TIMER_W (TIMER_W),
    .TICK_DIV(TICK_DIV),
    .DEAD_CYC(DEAD_CYC)
  ) i_ctrl (
    .clk          (clk),
    .rstN         (rstN),
    .photonValid  (photonValid),
    .countEnable  (countEnable),
    .cmdStart     (cmdStart),
    .cmdStop      (cmdStop),
    .cmdClear     (cmdClear),
    .rdReq        (rdReq),
    .ovfMode      (ovfMode),
    .collectTime  (collectTime),
    .repeatEnable (repeatEnable),
    .repeatTime   (repeatTime),
    .satHit       (satHit),
    .clearBusy    (clearBusy),
    .strobe       (strobe),
    .runActive    (runActive),
    .collecting   (collecting),
    .collectDone  (collectDone),
    .correctNeeded(correctNeeded)
  );

  phist_datapath #(
    .ADDR_W(ADDR_W),
    .CNT_W (CNT_W)
  ) i_datapath (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .photonAddr(photonAddr),
    .rdAddr    (rdAddr),
    .rdData    (rdData),
    .rdValid   (rdValid),
    .satHit    (satHit),
    .clearBusy (clearBusy)
  );

  // R8: clearing and collecting never overlap
  assert_clear_idle_R8: assert property (@(posedge clk) disable iff (!rstN)
    clearBusy |-> !collecting);

  // R11: read data only answers a request made while idle
  assert_read_idle_R11: assert property (@(posedge clk) disable iff (!rstN)
    rdValid |-> ($past(rdReq) && !$past(runActive) && !$past(clearBusy)));

endmodule

// File: tb/test_photon_histogram.sv
module test_photon_histogram;

  localparam int RW = 2;
  localparam int TW = 3;
  localparam int CW = 4;
  localparam int NCELL = 32;
  localparam int FULL = 15;
  localparam int TDIV = 2;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic photonValid = 1'b0;
  logic [TW-1:0] photonTime = '0;
  logic [RW-1:0] photonRoute = '0;
  logic countEnable = 1'b1;
  logic cmdStart = 1'b0, cmdStop = 1'b0, cmdClear = 1'b0;
  logic [1:0] ovfMode = 2'd0;
  logic [15:0] collectTime = 16'd5000;
  logic repeatEnable = 1'b0;
  logic [15:0] repeatTime = 16'd1;
  logic rdReq = 1'b0;
  logic [RW+TW-1:0] rdAddr = '0;

  logic [CW-1:0] rdDataA, rdDataB;
  logic rdValidA, rdValidB, runA, runB, colA, colB, doneA, doneB, corA, corB, busyA, busyB;

  int checks = 0;
  int fails = 0;
  int expA[NCELL];
  int expB[NCELL];

  always #5 clk = ~clk;

  photon_histogram #(.ROUTE_W(RW), .TIME_W(TW), .CNT_W(CW), .TIMER_W(16),
                     .TICK_DIV(TDIV), .DEAD_CYC(3)) i_photon_histogram (
    .clk(clk), .rstN(rstN), .photonValid(photonValid), .photonTime(photonTime),
    .photonRoute(photonRoute), .countEnable(countEnable), .cmdStart(cmdStart),
    .cmdStop(cmdStop), .cmdClear(cmdClear), .ovfMode(ovfMode),
    .collectTime(collectTime), .repeatEnable(repeatEnable), .repeatTime(repeatTime),
    .rdReq(rdReq), .rdAddr(rdAddr), .rdData(rdDataA), .rdValid(rdValidA),
    .runActive(runA), .collecting(colA), .collectDone(doneA),
    .correctNeeded(corA), .clearBusy(busyA));

  photon_histogram #(.ROUTE_W(RW), .TIME_W(TW), .CNT_W(CW), .TIMER_W(16),
                     .TICK_DIV(TDIV), .DEAD_CYC(1)) i_photon_histogram_nodead (
    .clk(clk), .rstN(rstN), .photonValid(photonValid), .photonTime(photonTime),
    .photonRoute(photonRoute), .countEnable(countEnable), .cmdStart(cmdStart),
    .cmdStop(cmdStop), .cmdClear(cmdClear), .ovfMode(ovfMode),
    .collectTime(collectTime), .repeatEnable(repeatEnable), .repeatTime(repeatTime),
    .rdReq(rdReq), .rdAddr(rdAddr), .rdData(rdDataB), .rdValid(rdValidB),
    .runActive(runB), .collecting(colB), .collectDone(doneB),
    .correctNeeded(corB), .clearBusy(busyB));

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int sat(input int v);
    return (v > FULL) ? FULL : v;
  endfunction

  task automatic readCell(input int a, output int dA, output int dB, output int vA, output int vB);
    @(negedge clk); rdReq = 1'b1; rdAddr = a[RW+TW-1:0];
    @(negedge clk); rdReq = 1'b0;
    dA = int'(rdDataA); dB = int'(rdDataB); vA = int'(rdValidA); vB = int'(rdValidB);
  endtask

  task automatic compareAll(input string req);
    int dA, dB, vA, vB;
    for (int a = 0; a < NCELL; a++) begin
      readCell(a, dA, dB, vA, vB);
      chk(req, $sformatf("rdValid cell %0d", a), vA & vB, 1);
      chk(req, $sformatf("cell %0d copy A", a), dA, expA[a]);
      chk(req, $sformatf("cell %0d copy B", a), dB, expB[a]);
    end
  endtask

  task automatic startRun();
    @(negedge clk); cmdStart = 1'b1;
    @(negedge clk); cmdStart = 1'b0;
  endtask

  task automatic stopRun();
    @(negedge clk); cmdStop = 1'b1;
    @(negedge clk); cmdStop = 1'b0;
  endtask

  // one photon, then gap-1 idle cycles
  task automatic shoot(input int route, input int tch, input int gap);
    @(negedge clk);
    photonValid = 1'b1; photonRoute = route[RW-1:0]; photonTime = tch[TW-1:0];
    @(negedge clk); photonValid = 1'b0;
    repeat (gap - 1) @(negedge clk);
  endtask

  task automatic testReset();
    chk("R9", "runActive after reset", int'(runA | runB), 0);
    chk("R9", "collectDone after reset", int'(doneA | doneB), 0);
    chk("R8", "clearBusy after reset", int'(busyA | busyB), 0);
    chk("R11", "rdValid after reset", int'(rdValidA | rdValidB), 0);
    chk("R6", "correctNeeded after reset", int'(corA | corB), 0);
  endtask

  task automatic testClear();
    int n = 0;
    @(negedge clk); cmdClear = 1'b1;
    @(negedge clk); cmdClear = 1'b0;
    while (busyA && n < 100) begin n++; @(negedge clk); end
    chk("R8", "clearBusy cycles", n, NCELL);
    chk("R8", "copy B busy ends with A", int'(busyB), 0);
    for (int a = 0; a < NCELL; a++) begin expA[a] = 0; expB[a] = 0; end
    compareAll("R8");
  endtask

  task automatic testBasic();
    ovfMode = 2'd0; collectTime = 16'd5000; repeatEnable = 1'b0;
    startRun();
    chk("R9", "collecting after start", int'(colA & colB & runA & runB), 1);
    shoot(1, 2, 4); shoot(3, 7, 4); shoot(0, 0, 4); shoot(2, 5, 4); shoot(1, 2, 4);
    expA[10] += 2; expA[31] += 1; expA[0] += 1; expA[21] += 1;
    expB[10] += 2; expB[31] += 1; expB[0] += 1; expB[21] += 1;
    // R3: gate low means no count
    countEnable = 1'b0; shoot(0, 1, 4); shoot(0, 1, 4); countEnable = 1'b1;
    stopRun();
    chk("R12", "runActive after stop", int'(runA | runB), 0);
    // R3: photon while idle is not counted
    shoot(0, 3, 4);
    compareAll("R2 R3");
  endtask

  task automatic testDead();
    startRun();
    @(negedge clk); photonValid = 1'b1; photonRoute = 2'd2; photonTime = 3'd1;
    repeat (7) @(negedge clk);
    photonValid = 1'b0;
    repeat (5) @(negedge clk);
    expA[17] += 3; expB[17] += 7;
    for (int i = 0; i < 6; i++) begin
      photonValid = 1'b1; photonRoute = 2'd1; photonTime = i[TW-1:0];
      @(negedge clk);
    end
    photonValid = 1'b0;
    expA[8] += 1; expA[11] += 1;
    for (int i = 0; i < 6; i++) expB[8 + i] += 1;
    repeat (4) @(negedge clk);
    stopRun();
    compareAll("R4 R7");
  endtask

  task automatic testSatNone();
    ovfMode = 2'd0;
    startRun();
    for (int i = 0; i < 20; i++) shoot(3, 0, 4);
    expA[24] = sat(expA[24] + 20); expB[24] = sat(expB[24] + 20);
    chk("R1", "run continues at full scale", int'(runA & runB), 1);
    stopRun();
    compareAll("R1");
  endtask

  task automatic testStop();
    ovfMode = 2'd1;
    startRun();
    shoot(3, 0, 4);
    chk("R5", "run ended copy A", int'(runA), 0);
    chk("R5", "run ended copy B", int'(runB), 0);
    shoot(0, 4, 4);
    compareAll("R5");
  endtask

  task automatic testRepeat();
    int n = 0;
    bit corSeen = 0;
    ovfMode = 2'd2; collectTime = 16'd20; repeatEnable = 1'b0;
    startRun();
    chk("R12", "correctNeeded clear at start", int'(corA | corB), 0);
    repeat (3) @(negedge clk);
    @(negedge clk); photonValid = 1'b1; photonRoute = 2'd3; photonTime = 3'd0;
    @(negedge clk); photonValid = 1'b0; n = 1;
    while (!doneA && n < 200) begin
      @(negedge clk); n++;
      if (n == 2) corSeen = corA & corB;
    end
    chk("R6", "correctNeeded set", int'(corSeen), 1);
    chk("R6", "done delay after restart", n, 20 * TDIV + 2);
    chk("R6", "copy B done together", int'(doneB), 1);
    @(negedge clk);
    chk("R9", "idle after done", int'(runA | runB), 0);
    ovfMode = 2'd0;
    startRun();
    chk("R12", "start clears correctNeeded", int'(corA | corB), 0);
    stopRun();
    compareAll("R6");
  endtask

  task automatic testTimer();
    int n = 0;
    ovfMode = 2'd0; collectTime = 16'd4; repeatEnable = 1'b0;
    startRun();
    while (!doneA && n < 100) begin @(negedge clk); n++; end
    chk("R9", "collection length", n, 4 * TDIV);
    chk("R9", "idle at done", int'(runA | colA), 0);
    @(negedge clk);
    chk("R9", "done one cycle", int'(doneA | doneB), 0);
    collectTime = 16'd3; repeatTime = 16'd2; repeatEnable = 1'b1;
    startRun();
    for (int s = 1; s <= 12; s++) begin
      @(negedge clk);
      chk("R10", $sformatf("collecting at %0d", s), int'(colA & colB), int'(s < 6 || s >= 10));
      chk("R10", $sformatf("done at %0d", s), int'(doneA), int'(s == 6));
      chk("R10", $sformatf("runActive at %0d", s), int'(runA), 1);
    end
    repeatEnable = 1'b0;
    stopRun();
    chk("R12", "stop from repeat", int'(runA | runB), 0);
  endtask

  task automatic testGuards();
    int dA, dB, vA, vB;
    collectTime = 16'd5000;
    startRun();
    readCell(10, dA, dB, vA, vB);
    chk("R11", "read while running ignored", vA | vB, 0);
    @(negedge clk); cmdClear = 1'b1;
    @(negedge clk); cmdClear = 1'b0;
    chk("R8", "clear while running ignored", int'(busyA | busyB), 0);
    stopRun();
    compareAll("R8 R11");
    @(negedge clk); cmdClear = 1'b1;
    @(negedge clk); cmdClear = 1'b0;
    readCell(10, dA, dB, vA, vB);
    chk("R11", "read while clearing ignored", vA | vB, 0);
    while (busyA) @(negedge clk);
    for (int a = 0; a < NCELL; a++) begin expA[a] = 0; expB[a] = 0; end
    compareAll("R8");
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testClear();
    testBasic();
    testDead();
    testSatNone();
    testStop();
    testRepeat();
    testTimer();
    testGuards();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule